// File: doc/BRIEF.md
# Fractional-N Feedback Divider Chain

This block is the feedback divider of a frequency synthesizer. It runs entirely on the oscillator clock and divides it by an integer ratio N = P·B + A. P is the base modulus of a two-modulus prescaler. A swallow count A decides how many prescaler periods run at the longer modulus P+1. A main count B sets how many prescaler periods make up one divide cycle. When the main count expires, every counter in the chain reloads and a new divide cycle begins. The block emits one single-clock pulse for each completed divide cycle.

A 5-bit phase accumulator steps by a programmable increment I once per divide cycle. In any divide cycle where that step wraps past 32, the chain runs one extra prescaler period at P+1, which lengthens the cycle by one oscillator clock. The long-run ratio is therefore N + I/32. With I = 0 the block behaves as a plain integer divider.

The configuration inputs are sampled only at the reload boundary. A divide cycle therefore never mixes old and new settings.

Top module: `fracn_fb_divider`

## Requirements
- R1: While `rst` is high, `fb_pulse` stays low. The first clock edge with `rst` low starts the first divide cycle without producing a pulse. The first pulse is seen after clock edge N+1, counted from that first edge.
- R2: With increment 0, consecutive pulses are exactly N = P·B + A clocks apart, where P = `PRE_P` (default 8), B = `main_ld` and A = `swallow_ld`.
- R3: The accumulator starts at 0 after reset and adds `frac_step` once at every reload, modulo 32. A divide cycle whose reload makes that sum reach 32 or more lasts N+1 clocks. Every other divide cycle lasts N clocks.
- R4: Over any 32 consecutive divide cycles with a fixed configuration, the total length is 32·N + I clocks.
- R5: With increment 0, no divide cycle is ever stretched.
- R6: Each pulse is exactly one clock wide.
- R7: `main_ld`, `swallow_ld` and `frac_step` are sampled only at a reload. A change made in the middle of a divide cycle leaves that cycle's length unchanged and applies from the next cycle.
- R8: A swallow count of 0 gives N = P·B. A swallow count of B−1 with a nonzero increment still gives N+1 on overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator input clock |
| rst | input | 1 | Synchronous active-high reset |
| main_ld | input | B_W (6) | Main count B: prescaler periods per divide cycle |
| swallow_ld | input | A_W (4) | Swallow count A: prescaler periods at modulus P+1 |
| frac_step | input | FRAC_W (5) | Fractional increment I, in 1/32 steps |
| fb_pulse | output | 1 | One-clock pulse at the end of each divide cycle |

## Verification
The checker assumes that `main_ld` is nonzero whenever a reload samples it. It also assumes that `main_ld` is at least `swallow_ld`, and strictly greater whenever `frac_step` is nonzero, so the stretched swallow count still fits within the main count. Under those conditions every measured cycle length is either N or N+1. Every configuration the stimulus applies satisfies this, including the tightest case where the swallow count is one below the main count. Mid-cycle configuration changes are made only between pulses, and the new values also satisfy the rule.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
   localparam int FRAC_BITS = 5;
   localparam int FRAC_MOD  = 1 << FRAC_BITS;

   // integer ratio of the chain for a given prescaler modulus and counts
   function automatic int base_ratio(input int p, input int b, input int a);
      return p * b + a;
   endfunction
endpackage

// File: rtl/fracn_accum.sv
module fracn_accum #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         step,
   input  logic [W-1:0] incr,
   output logic         carry_o
);
   logic [W-1:0] acc_q;
   logic [W:0]   sum;

   assign sum     = {1'b0, acc_q} + {1'b0, incr};
   assign carry_o = sum[W];

   always_ff @(posedge clk) begin
      if (rst)       acc_q <= '0;
      else if (step) acc_q <= sum[W-1:0];
   end
endmodule

// File: rtl/fracn_prescaler.sv
module fracn_prescaler #(
   parameter int PRE_P = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic restart,
   input  logic hi_sel,
   output logic end_o
);
   localparam int PC_W = $clog2(PRE_P + 1);
   logic [PC_W-1:0] pc_q;

   assign end_o = (pc_q == '0);

   always_ff @(posedge clk) begin
      if (rst)          pc_q <= '0;
      else if (restart) pc_q <= hi_sel ? PC_W'(PRE_P) : PC_W'(PRE_P - 1);
      else              pc_q <= pc_q - 1'b1;
   end
endmodule

// File: rtl/fracn_swallow.sv
module fracn_swallow #(
   parameter int B_W = 6,
   parameter int A_W = 4
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           load,
   input  logic           pre_end,
   input  logic [B_W-1:0] b_ld,
   input  logic [A_W:0]   a_eff,
   output logic           term_o,
   output logic           hi_next_o
);
   logic [B_W-1:0] bc_q;
   logic [A_W:0]   ac_q;

   assign term_o    = pre_end && (bc_q == B_W'(1));
   assign hi_next_o = load ? (a_eff != '0) : (ac_q > (A_W+1)'(1));

   always_ff @(posedge clk) begin
      if (rst) begin
         bc_q <= '0;
         ac_q <= '0;
      end else if (load) begin
         bc_q <= b_ld;
         ac_q <= a_eff;
      end else if (pre_end) begin
         bc_q <= bc_q - 1'b1;
         ac_q <= (ac_q != '0) ? ac_q - 1'b1 : '0;
      end
   end
endmodule

// File: rtl/fracn_fb_divider.sv
module fracn_fb_divider #(
   parameter int PRE_P     = 8,
   parameter int B_W       = 6,
   parameter int A_W       = 4,
   parameter int FRAC_W    = fracn_pkg::FRAC_BITS,
   parameter bit PULSE_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [B_W-1:0]    main_ld,
   input  logic [A_W-1:0]    swallow_ld,
   input  logic [FRAC_W-1:0] frac_step,
   output logic              fb_pulse
);
   if (PRE_P < 2) begin : g_bad_p
      $error("PRE_P must be at least 2");
   end
   if (A_W > B_W) begin : g_bad_w
      $error("A_W must not exceed B_W");
   end

   logic         start_q;
   logic         load;
   logic         term;
   logic         carry;
   logic         pre_end;
   logic         hi_next;
   logic [A_W:0] a_eff;

   always_ff @(posedge clk) begin
      if (rst) start_q <= 1'b1;
      else     start_q <= 1'b0;
   end

   assign load  = start_q | term;
   assign a_eff = {1'b0, swallow_ld} + {{A_W{1'b0}}, carry};

   fracn_accum #(.W(FRAC_W)) u_acc (
      .clk(clk), .rst(rst), .step(load), .incr(frac_step), .carry_o(carry)
   );

   fracn_prescaler #(.PRE_P(PRE_P)) u_pre (
      .clk(clk), .rst(rst), .restart(load | pre_end), .hi_sel(hi_next),
      .end_o(pre_end)
   );

   fracn_swallow #(.B_W(B_W), .A_W(A_W)) u_cnt (
      .clk(clk), .rst(rst), .load(load), .pre_end(pre_end), .b_ld(main_ld),
      .a_eff(a_eff), .term_o(term), .hi_next_o(hi_next)
   );

   if (PULSE_REG) begin : g_pulse_reg
      logic pulse_q;
      always_ff @(posedge clk) begin
         if (rst) pulse_q <= 1'b0;
         else     pulse_q <= term;
      end
      assign fb_pulse = pulse_q;
   end else begin : g_pulse_comb
      assign fb_pulse = term & ~rst;
   end
endmodule

// File: rtl/fracn_fb_divider_chk.sv
module fracn_fb_divider_chk #(
   parameter int PRE_P     = 8,
   parameter int B_W       = 6,
   parameter int A_W       = 4,
   parameter int FRAC_W    = 5,
   parameter bit PULSE_REG = 1'b1
) (
   input logic              clk,
   input logic              rst,
   input logic              load,
   input logic [B_W-1:0]    main_ld,
   input logic [A_W-1:0]    swallow_ld,
   input logic [FRAC_W-1:0] frac_step,
   input logic              fb_pulse
);
   logic              seen;
   int                since;
   int                len;
   int                base;
   logic [FRAC_W-1:0] i_c;
   logic [B_W-1:0]    b_c;
   logic [A_W-1:0]    a_c;

   always_ff @(posedge clk) begin
      if (rst) begin
         seen  <= 1'b0;
         since <= 0;
         b_c   <= '0;
         a_c   <= '0;
         i_c   <= '0;
      end else if (load) begin
         seen  <= 1'b1;
         since <= 0;
         b_c   <= main_ld;
         a_c   <= swallow_ld;
         i_c   <= frac_step;
      end else begin
         since <= since + 1;
      end
   end

   assign len  = since + 1;
   assign base = fracn_pkg::base_ratio(PRE_P, int'(b_c), int'(a_c));

   AST_CFG_LEGAL: assert property (@(posedge clk) disable iff (rst)
      load |-> (main_ld != '0) && ((int'(main_ld) > int'(swallow_ld)) ||
               ((int'(main_ld) == int'(swallow_ld)) && (frac_step == '0)))); // R8

   AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
      (load && seen) |-> (len == base || len == base + 1)); // R3

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      (load && seen && i_c == '0) |-> (len == base)); // R5

   AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
      fb_pulse |=> !fb_pulse); // R6

   AST_NO_EARLY_PULSE: assert property (@(posedge clk) disable iff (rst)
      !seen |-> !fb_pulse); // R1

   if (PULSE_REG) begin : g_reg
      AST_PULSE_AT_END: assert property (@(posedge clk) disable iff (rst)
         (load && seen) |=> fb_pulse); // R2
   end else begin : g_comb
      AST_PULSE_AT_END: assert property (@(posedge clk) disable iff (rst)
         (load && seen) |-> fb_pulse); // R2
   end
endmodule

bind fracn_fb_divider fracn_fb_divider_chk #(
   .PRE_P(PRE_P), .B_W(B_W), .A_W(A_W), .FRAC_W(FRAC_W), .PULSE_REG(PULSE_REG)
) u_chk (
   .clk(clk), .rst(rst), .load(load), .main_ld(main_ld),
   .swallow_ld(swallow_ld), .frac_step(frac_step), .fb_pulse(fb_pulse)
);

// File: tb/fracn_fb_divider_test.sv
module fracn_fb_divider_test;
   localparam int P = 8;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [5:0] main_ld = 6'd5;
   logic [3:0] swallow_ld = 4'd3;
   logic [4:0] frac_step = 5'd0;
   logic       fb_pulse;

   int checks = 0;
   int fails  = 0;

   always #4ns clk = ~clk;

   fracn_fb_divider uut (
      .clk(clk), .rst(rst), .main_ld(main_ld), .swallow_ld(swallow_ld),
      .frac_step(frac_step), .fb_pulse(fb_pulse)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic apply(input int b, input int a, input int i);
      @(negedge clk);
      main_ld = 6'(b); swallow_ld = 4'(a); frac_step = 5'(i);
   endtask

   // R1: output quiet in reset, first pulse after edge N+1
   task automatic do_reset(input int n_first);
      int k;
      int bad;
      @(negedge clk);
      rst = 1'b1;
      bad = 0;
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         if (fb_pulse) bad++;
      end
      check("R1 pulse during reset", bad, 0);
      rst = 1'b0;
      k = 0;
      do begin
         @(negedge clk);
         k++;
      end while (!fb_pulse && k < 2000);
      check("R1 first pulse latency", k, n_first + 1);
   endtask

   // clocks until the next pulse; also checks the width of the last one (R6)
   task automatic next_gap(output int g);
      g = 0;
      do begin
         @(negedge clk);
         g++;
         if (g == 1) check("R6 pulse width", int'(fb_pulse), 0);
      end while (!fb_pulse && g < 2000);
   endtask

   task automatic run_frac(input string tag, input int b, input int a, input int i,
                           input int ncyc);
      int n, acc, s, exp, g, total, bad;
      n = P * b + a;
      main_ld = 6'(b); swallow_ld = 4'(a); frac_step = 5'(i);
      do_reset(n);
      acc = i;   // accumulator after the first reload
      total = 0;
      bad = 0;
      for (int j = 0; j < ncyc; j++) begin
         s   = acc + i;
         exp = n + ((s >= 32) ? 1 : 0);
         acc = s % 32;
         next_gap(g);
         check({tag, " cycle length"}, g, exp);
         if (j < 32) total += g;
      end
      if (ncyc >= 32) check({tag, " R4 sum over 32 cycles"}, total, 32 * n + i);
      if (i == 0) begin
         // R5: never stretched with zero increment
         for (int j = 0; j < 8; j++) begin
            next_gap(g);
            if (g != n) bad++;
         end
         check({tag, " R5 no stretch"}, bad, 0);
      end
   endtask

   // R7: mid-cycle change only affects the following divide cycle
   task automatic shadow_test();
      int g;
      main_ld = 6'd5; swallow_ld = 4'd3; frac_step = 5'd0;
      do_reset(43);
      repeat (3) @(negedge clk);
      main_ld = 6'd4; swallow_ld = 4'd1;
      next_gap(g);
      g = g + 3;
      check("R7 running cycle keeps old ratio", g, 43);
      next_gap(g);
      check("R7 next cycle uses new ratio", g, 33);
   endtask

   initial begin
      #(8ns * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      apply(5, 3, 0);
      run_frac("R2 integer", 5, 3, 0, 36);
      run_frac("R3 I=1", 5, 3, 1, 34);
      run_frac("R3 I=8", 6, 2, 8, 33);
      run_frac("R8 A=0", 4, 0, 5, 33);
      run_frac("R8 A=B-1 I=31", 3, 2, 31, 33);
      run_frac("R3 I=16", 7, 6, 16, 33);
      shadow_test();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule